// File: doc/BRIEF.md
# Dual-Rail Ripple Constant Multiplier (x3 / x5)

This block multiplies an unsigned operand by a fixed constant of the form two-to-the-K plus one. It forms the operand plus a copy of itself shifted left by K places in one addition, so no multiplier array is needed. A parameter selects K = 1 (times three) or K = 2 (times five). The adder is a ripple chain of unit cells. Between cells the carry is not a single bit. It is a set of AND/OR rails derived by Shannon expansion on the current operand bit, so each cell adds only one two-input gate level to the carry path.

For K = 1 each cell covers one result bit and passes a two-rail pair. For K = 2 each cell covers two result bits and passes four rails. Each of the four rails crosses two gates per cell, and the gate at each level is an OR or an AND according to that rail's index bit. Inside a cell a small selector rebuilds the true incoming carry from the rails and the operand bits it already holds. An XOR stage then forms the sum. When the operand width is odd under K = 2, it is padded with zero bits up to a whole number of cells. The product is captured in one output register with a synchronous active-low reset.

Top module: `dual_rail_cmul`

## Requirements
- R1: With SHIFT_K = 1, `product` equals 3 × `operand` as an unsigned value of DATA_W+2 bits.
- R2: With SHIFT_K = 2, `product` equals 5 × `operand` as an unsigned value of DATA_W+3 bits.
- R3: With SHIFT_K = 2 and an odd DATA_W, the result is still exact. The operand is zero-padded at the top, and no padding bit reaches the product.
- R4: While `rst_n` is low at a rising clock edge, `product` becomes zero at that edge. This overrides any operand value.
- R5: `product` reflects the operand sampled at the previous rising edge. A change of `operand` between edges does not alter `product` until the next edge.
- R6: Bit 0 of `product` equals bit 0 of the operand that was sampled, since both multipliers are odd.
- R7: The all-ones operand gives the largest product without wrap-around: 3 × (2^DATA_W − 1) for SHIFT_K = 1, and 5 × (2^DATA_W − 1) for SHIFT_K = 2.
- R8: A zero operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| operand | input | DATA_W | Unsigned multiplicand |
| product | output | DATA_W+SHIFT_K+1 | Registered product, operand × (2^SHIFT_K + 1) |

## Verification
A wrong rail value in one cell corrupts the sum bit it feeds and every higher bit it ripples into. The wrong value shows as a bad `product` on the very next clock edge after that operand is applied. The rail encodings have ordering invariants: the AND rail never exceeds the OR rail, and in the four-rail case the rails are monotonic in their index bits. A broken gate type or a swapped rail index therefore shows up for only some operand patterns. For that reason every operand value is applied for both multipliers and for an odd width, and each result is compared in its own cycle.

// File: rtl/dual_rail_cmul_pkg.sv
`timescale 1ns/1ps
// Shared rail types for the dual-rail ripple constant multiplier.
// Assumes: rails are active-high; index bits of the quad name the gate
// kind at each level (1 = OR, 0 = AND), outer level in the upper bit.
package dual_rail_cmul_pkg;

    // Carry rails of a one-bit cell: AND and OR of previous bit with its carry.
    typedef struct packed {
        logic w_or;
        logic w_and;
    } rail_pair_t;

    // Carry rails of a two-bit cell, index {outer, inner}.
    typedef logic [3:0] rail_quad_t;

    // Number of cells needed to cover a given result width.
    function automatic int unsigned cells_for(input int unsigned bits, input int unsigned per_cell);
        return (bits + per_cell - 1) / per_cell;
    endfunction

endpackage

// File: rtl/dual_rail_cell_x1.sv
`timescale 1ns/1ps
// One-bit unit cell for the times-three chain.
// Adds cur_bit + prv_bit + carry, where the carry arrives as the rail pair
// (prv_bit AND carry, prv_bit OR carry). Assumes rails from the previous
// cell are consistent (AND rail implies OR rail).
module dual_rail_cell_x1
    import dual_rail_cmul_pkg::*;
(
    input  logic       cur_bit,
    input  logic       prv_bit,
    input  rail_pair_t rail_in,
    output rail_pair_t rail_out,
    output logic       sum_bit
);

    logic carry_in;

    // Carry propagation: one gate per rail, selected by Shannon expansion on cur_bit.
    always_comb begin
        rail_out.w_and = cur_bit & rail_in.w_or;
        rail_out.w_or  = cur_bit | rail_in.w_and;
    end

    // u-function: rebuild the true carry from the rails and prv_bit.
    always_comb begin
        carry_in = prv_bit ? rail_in.w_and : rail_in.w_or;
    end

    // Sum generation.
    always_comb begin
        sum_bit = cur_bit ^ prv_bit ^ carry_in;
    end

    // Incoming rails must be ordered; a broken neighbour breaks R1.
    always_comb begin
        assert_rail_order_R1: assert (!rail_in.w_and || rail_in.w_or);
    end

endmodule

// File: rtl/dual_rail_cell_x2.sv
`timescale 1ns/1ps
// Two-bit unit cell for the times-five chain.
// Result bits 2j and 2j+1 add cur_bits + prv_bits (operand shifted by two)
// + carry. Carry state is four rails Q{x,y} = gx(hi, gy(lo, c)) where g1 is
// OR and g0 is AND, taken over the previous cell's operand bits.
// Assumes rails from the previous cell are monotonic in their index.
module dual_rail_cell_x2
    import dual_rail_cmul_pkg::*;
(
    input  logic [1:0] cur_bits,
    input  logic [1:0] prv_bits,
    input  rail_quad_t rail_in,
    output rail_quad_t rail_out,
    output logic [1:0] sum_bits
);

    logic carry_lo;
    logic carry_hi;

    // Carry propagation: four paths, two gates each (inner on bit 0, outer on bit 1).
    always_comb begin
        rail_out[0] = cur_bits[1] & (cur_bits[0] & rail_in[3]);
        rail_out[1] = cur_bits[1] & (cur_bits[0] | rail_in[2]);
        rail_out[2] = cur_bits[1] | (cur_bits[0] & rail_in[1]);
        rail_out[3] = cur_bits[1] | (cur_bits[0] | rail_in[0]);
    end

    // u-function: pick the rails whose gates pass the carry unchanged.
    always_comb begin
        carry_lo = rail_in[{~prv_bits[1], ~prv_bits[0]}];
        carry_hi = rail_in[{~prv_bits[1],  cur_bits[0]}];
    end

    // Sum generation for both bits.
    always_comb begin
        sum_bits[0] = cur_bits[0] ^ prv_bits[0] ^ carry_lo;
        sum_bits[1] = cur_bits[1] ^ prv_bits[1] ^ carry_hi;
    end

    // Rails must be monotonic in each index bit; otherwise R2 is broken.
    always_comb begin
        assert_quad_inner_R2: assert ((!rail_in[0] || rail_in[1]) && (!rail_in[2] || rail_in[3]));
        assert_quad_outer_R2: assert ((!rail_in[0] || rail_in[2]) && (!rail_in[1] || rail_in[3]));
    end

endmodule

// File: rtl/dual_rail_chain.sv
`timescale 1ns/1ps
// Ripple chain of unit cells computing operand * (2^SHIFT_K + 1).
// SHIFT_K = 1 uses one-bit cells, SHIFT_K = 2 uses two-bit cells.
// Assumes SHIFT_K is 1 or 2; the operand is zero-padded to whole cells.
module dual_rail_chain
    import dual_rail_cmul_pkg::*;
#(
    parameter int unsigned DATA_W  = 10,
    parameter int unsigned SHIFT_K = 1
) (
    input  logic [DATA_W-1:0]         operand,
    output logic [DATA_W+SHIFT_K:0]   result
);

    localparam int unsigned OUT_W = DATA_W + SHIFT_K + 1;
    localparam int unsigned CELLS = cells_for(OUT_W, SHIFT_K);
    localparam int unsigned PAD_W = CELLS * SHIFT_K;

    logic [PAD_W-1:0] padded;
    logic [PAD_W-1:0] shifted;
    logic [PAD_W-1:0] sums;

    // Zero-extend the operand and form the shifted addend.
    always_comb begin
        padded  = PAD_W'(operand);
        shifted = padded << SHIFT_K;
    end

    assign result = sums[OUT_W-1:0];

    if (SHIFT_K == 1) begin : g_x3
        rail_pair_t rails [CELLS+1];
        assign rails[0] = '0;

        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            dual_rail_cell_x1 u_cell (
                .cur_bit  (padded[i]),
                .prv_bit  (shifted[i]),
                .rail_in  (rails[i]),
                .rail_out (rails[i+1]),
                .sum_bit  (sums[i])
            );
        end

        // Final rails carry nothing out: the product fits its width (R1).
        always_comb begin
            assert_no_overflow_R1: assert (rails[CELLS] == '0);
        end
    end else begin : g_x5
        rail_quad_t rails [CELLS+1];
        assign rails[0] = '0;

        for (genvar j = 0; j < CELLS; j++) begin : g_cell
            dual_rail_cell_x2 u_cell (
                .cur_bits (padded[2*j +: 2]),
                .prv_bits (shifted[2*j +: 2]),
                .rail_in  (rails[j]),
                .rail_out (rails[j+1]),
                .sum_bits (sums[2*j +: 2])
            );
        end

        // Final rails empty and padding sum bits zero (R2, R3).
        always_comb begin
            assert_no_overflow_R2: assert (rails[CELLS] == '0);
            assert_pad_clear_R3: assert (PAD_W == OUT_W || sums[PAD_W-1] == 1'b0);
        end
    end

endmodule

// File: rtl/dual_rail_cmul.sv
`timescale 1ns/1ps
// Top: registered constant multiplier, product = operand * (2^SHIFT_K + 1).
// Combinational dual-rail ripple chain followed by one output register
// with synchronous active-low reset. Assumes SHIFT_K is 1 or 2.
module dual_rail_cmul #(
    parameter int unsigned DATA_W  = 10,
    parameter int unsigned SHIFT_K = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DATA_W-1:0]         operand,
    output logic [DATA_W+SHIFT_K:0]   product
);

    localparam int unsigned OUT_W = DATA_W + SHIFT_K + 1;
    localparam int unsigned MULT  = (1 << SHIFT_K) + 1;

    logic [OUT_W-1:0] chain_sum;

    dual_rail_chain #(
        .DATA_W  (DATA_W),
        .SHIFT_K (SHIFT_K)
    ) u_chain (
        .operand (operand),
        .result  (chain_sum)
    );

    // Output register: clear on reset, else capture the chain result.
    always_ff @(posedge clk) begin
        if (!rst_n) product <= '0;
        else        product <= chain_sum;
    end

    // Product of the previous operand (R1/R2 and R5 together).
    assert_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> product == OUT_W'(MULT) * OUT_W'($past(operand)));

    // Low bit follows low operand bit.
    assert_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> product[0] == $past(operand[0]));

    // Reset clears the register.
    assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> product == '0);

    // Zero in, zero out.
    assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(operand) == '0) |-> product == '0);

endmodule

// File: tb/test_dual_rail_cmul.sv
`timescale 1ns/1ps
// Bench: three instances (x3 n=10, x5 n=10, x5 n=9) driven with every
// operand value; a queue-based reference model is compared each clock.
module test_dual_rail_cmul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  opnd = '0;
    logic [11:0] p3;
    logic [12:0] p5;
    logic [11:0] p5o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int q3[$];
    int q5[$];
    int q5o[$];

    always #4 clk = ~clk;

    dual_rail_cmul #(.DATA_W(10), .SHIFT_K(1)) i_dual_rail_cmul (
        .clk(clk), .rst_n(rst_n), .operand(opnd), .product(p3));

    dual_rail_cmul #(.DATA_W(10), .SHIFT_K(2)) i_dual_rail_cmul_x5 (
        .clk(clk), .rst_n(rst_n), .operand(opnd), .product(p5));

    dual_rail_cmul #(.DATA_W(9), .SHIFT_K(2)) i_dual_rail_cmul_odd (
        .clk(clk), .rst_n(rst_n), .operand(opnd[8:0]), .product(p5o));

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Drive one operand and push reference products.
    task automatic drive(input int v);
        opnd = 10'(v);
        q3.push_back(3 * v);
        q5.push_back(5 * v);
        q5o.push_back(5 * (v % 512));
    endtask

    // Compare registered outputs against the oldest reference entries.
    task automatic compare(input string tag3, input string tag5, input int v);
        check(tag3, int'(p3), q3.pop_front());
        check(tag5, int'(p5), q5.pop_front());
        check({"R3 ", tag5}, int'(p5o), q5o.pop_front());
        check("R6 lsb", int'(p3[0]), v % 2);
    endtask

    initial begin
        int prev3;
        // R4: product is zero while reset is held
        repeat (3) @(negedge clk);
        opnd = 10'h3FF;
        @(negedge clk);
        check("R4 reset x3", int'(p3), 0);
        check("R4 reset x5", int'(p5), 0);
        check("R4 reset odd", int'(p5o), 0);
        rst_n = 1'b1;
        drive(0);
        @(negedge clk);
        compare("R8 zero x3", "R8 zero x5", 0);
        prev3 = 0;

        // R1, R2, R3, R5: every operand value
        for (int v = 1; v < 1024; v++) begin
            drive(v);
            #1;
            check("R5 holds until edge", int'(p3), prev3);
            @(negedge clk);
            if (v == 1023) compare("R7 max x3", "R7 max x5", v);
            else           compare("R1 x3", "R2 x5", v);
            prev3 = 3 * v;
        end

        // R4: reset at an edge overrides a nonzero operand
        rst_n = 1'b0;
        opnd  = 10'h155;
        @(negedge clk);
        check("R4 mid-run x3", int'(p3), 0);
        check("R4 mid-run x5", int'(p5), 0);
        rst_n = 1'b1;
        drive(1023);
        @(negedge clk);
        compare("R7 max x3", "R7 max x5", 1023);
        drive(0);
        @(negedge clk);
        compare("R8 zero x3", "R8 zero x5", 0);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule